// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Bank

This block is the software-visible register file of a multi-ring Ethernet DMA controller. A host writes and reads 32-bit words through a simple strobe interface. Each word sits in a 4 KiB window, and only the word index (byte address bits 11:2) reaches the block. Every location has an access type: read-write, write-only, write-one-to-clear, read-only, or unknown. Unknown locations read as zero, and writes to them do nothing.

The bank holds an interrupt event word and a mask word. Hardware raises event bits through `evt_set`. Software clears them by writing ones. The active set is event AND mask. It is folded into three registered interrupt lines: transmit, receive and error. Each of the eight transmit rings and eight receive rings has a base register and a current-pointer register. A base write is aligned to 8 bytes and mirrored into the pointer.

Two halt-status words hold one flag per ring. The DMA engine sets a flag through `tx_halt_set` or `rx_halt_set`. Software clears flags by writing ones, and that write also emits one-cycle restart pulses to the engine. Register access is a control path with no back-pressure: a write strobe takes effect at the clock edge it is sampled on, and read data is combinational from the address.

Top module: `dma_csr_bank`

## Requirements
- R1: The word index is `csr_addr` (byte address bits 11:2). The defined byte offsets are:
  - 0x000 event, 0x004 mask, 0x008 control, 0x00C command, 0x010 identity
  - 0x020 transmit halt status, 0x024 receive halt status
  - 0x100+4i transmit base i, 0x120+4i transmit pointer i
  - 0x140+4i receive base i, 0x160+4i receive pointer i

  Any other offset reads 0 and ignores writes.
- R2: The mask and control words are read-write. They read back the last written value, and control is also driven on `ctrl_word`.
- R3: The command word is write-only. It reads 0, and the written value appears on `cmd_word`. The identity word is read-only: it always reads `ID_VALUE`, and writes are ignored.
- R4: The event word is write-one-to-clear. `evt_set` bits are ORed in at the same edge, and a set wins over a same-cycle clear of that bit.
- R5: `irq_tx`, `irq_rx` and `irq_err` are high when event AND mask has a bit inside their group. The default groups are bits 7:0, bits 15:8 and bits 31:16. Each line is registered: it follows a register change one edge later.
- R6: A base write stores the value with bits 2:0 forced to 0 and copies that same value into the ring's pointer. A pointer write stores the full value.
- R7: In the transmit halt word, bit 31-i is the flag of ring i, set by `tx_halt_set[i]`. Writing 1 to it clears the flag and makes `tx_kick[i]` high for the cycle after the write edge. A same-cycle set wins over the clear.
- R8: In the receive halt word, bit 23-i is the flag of ring i. Writing 1 to it clears the flag. `rx_kick[i]` pulses only if that bit was written 1 while the stored flag was 0.
- R9: After reset, every register is 0 except identity (`ID_VALUE`), and all interrupt and kick outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Write strobe, applied at the clock edge |
| csr_addr | input | 10 | Word index (byte address bits 11:2) |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for `csr_addr` |
| evt_set | input | 32 | Hardware event set bits |
| tx_halt_set | input | 8 | Transmit ring halt set, one bit per ring |
| rx_halt_set | input | 8 | Receive ring halt set, one bit per ring |
| irq_tx | output | 1 | Transmit group interrupt |
| irq_rx | output | 1 | Receive group interrupt |
| irq_err | output | 1 | Error group interrupt |
| tx_kick | output | 8 | Transmit ring restart pulses |
| rx_kick | output | 8 | Receive ring restart pulses |
| cmd_word | output | 32 | Last value written to the command word |
| ctrl_word | output | 32 | Current control word |

## Verification
Stored values are visible on `csr_rdata` as soon as the write edge has passed, and restart pulses are high for that same following cycle. The bench drives each write on a falling edge and releases it on the next falling edge, then samples there. Interrupt lines lag the event or mask change by one more edge. The bench therefore first confirms the old level at the falling edge after the write, then checks the new level one falling edge later.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int NUM_RINGS = 8;
  localparam int RING_W    = $clog2(NUM_RINGS);
  localparam int DW        = 32;
  localparam int IDX_W     = 10;

  typedef enum logic [3:0] {
    K_NONE, K_EVENT, K_MASK, K_CTRL, K_CMD, K_ID,
    K_TXSTAT, K_RXSTAT, K_TXBASE, K_TXPTR, K_RXBASE, K_RXPTR
  } reg_kind_e;

  typedef enum logic [2:0] {
    ACC_UNKNOWN, ACC_RW, ACC_WO, ACC_W1C, ACC_RO
  } acc_e;

  typedef struct packed {
    reg_kind_e          kind;
    acc_e               acc;
    logic [RING_W-1:0]  ring;
  } dec_t;

  function automatic acc_e acc_of(reg_kind_e k);
    case (k)
      K_EVENT, K_TXSTAT, K_RXSTAT:                 return ACC_W1C;
      K_MASK, K_CTRL, K_TXBASE, K_TXPTR,
      K_RXBASE, K_RXPTR:                           return ACC_RW;
      K_CMD:                                       return ACC_WO;
      K_ID:                                        return ACC_RO;
      default:                                     return ACC_UNKNOWN;
    endcase
  endfunction
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
(
  input  logic [IDX_W-1:0] widx,
  output dec_t             dec
);
  localparam int GRP_W = IDX_W - RING_W;

  reg_kind_e kind;

  always_comb begin
    kind = K_NONE;
    case (widx[IDX_W-1:RING_W])
      GRP_W'(0): begin
        case (widx[RING_W-1:0])
          RING_W'(0): kind = K_EVENT;
          RING_W'(1): kind = K_MASK;
          RING_W'(2): kind = K_CTRL;
          RING_W'(3): kind = K_CMD;
          RING_W'(4): kind = K_ID;
          default:    kind = K_NONE;
        endcase
      end
      GRP_W'(1): begin
        case (widx[RING_W-1:0])
          RING_W'(0): kind = K_TXSTAT;
          RING_W'(1): kind = K_RXSTAT;
          default:    kind = K_NONE;
        endcase
      end
      GRP_W'(8):  kind = K_TXBASE;
      GRP_W'(9):  kind = K_TXPTR;
      GRP_W'(10): kind = K_RXBASE;
      GRP_W'(11): kind = K_RXPTR;
      default:    kind = K_NONE;
    endcase
  end

  assign dec.kind = kind;
  assign dec.acc  = acc_of(kind);
  assign dec.ring = widx[RING_W-1:0];
endmodule

// File: rtl/dma_csr_rings.sv
module dma_csr_rings #(
  parameter int N      = 8,
  parameter int W      = 32,
  parameter int ALIGN  = 3,
  localparam int SEL_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                base_we,
  input  logic                ptr_we,
  input  logic [SEL_W-1:0]    sel,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] base_q,
  output logic [N-1:0][W-1:0] ptr_q
);
  logic [W-1:0] aligned;
  assign aligned = {wdata[W-1:ALIGN], {ALIGN{1'b0}}};

  for (genvar r = 0; r < N; r++) begin : g_ring
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[r] <= '0;
        ptr_q[r]  <= '0;
      end else if (base_we && sel == SEL_W'(r)) begin
        base_q[r] <= aligned;
        ptr_q[r]  <= aligned;
      end else if (ptr_we && sel == SEL_W'(r)) begin
        ptr_q[r]  <= wdata;
      end
    end
  end

  assert_ptr_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(base_we) |-> ptr_q[$past(sel)] == base_q[$past(sel)]);
  assert_base_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(base_we) |-> base_q[$past(sel)][ALIGN-1:0] == '0);
endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq #(
  parameter int          W       = 32,
  parameter logic [W-1:0] TX_GRP  = 32'h0000_00FF,
  parameter logic [W-1:0] RX_GRP  = 32'h0000_FF00,
  parameter logic [W-1:0] ERR_GRP = 32'hFFFF_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] event_q,
  input  logic [W-1:0] mask_q,
  output logic         irq_tx,
  output logic         irq_rx,
  output logic         irq_err
);
  logic [W-1:0] active;
  assign active = event_q & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_tx  <= |(active & TX_GRP);
      irq_rx  <= |(active & RX_GRP);
      irq_err <= |(active & ERR_GRP);
    end
  end
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0DA0_0001,
  parameter logic [31:0] TX_GRP   = 32'h0000_00FF,
  parameter logic [31:0] RX_GRP   = 32'h0000_FF00,
  parameter logic [31:0] ERR_GRP  = 32'hFFFF_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_wr,
  input  logic [IDX_W-1:0]     csr_addr,
  input  logic [DW-1:0]        csr_wdata,
  output logic [DW-1:0]        csr_rdata,
  input  logic [DW-1:0]        evt_set,
  input  logic [NUM_RINGS-1:0] tx_halt_set,
  input  logic [NUM_RINGS-1:0] rx_halt_set,
  output logic                 irq_tx,
  output logic                 irq_rx,
  output logic                 irq_err,
  output logic [NUM_RINGS-1:0] tx_kick,
  output logic [NUM_RINGS-1:0] rx_kick,
  output logic [DW-1:0]        cmd_word,
  output logic [DW-1:0]        ctrl_word
);
  localparam int TX_TOP = DW - 1;
  localparam int RX_TOP = DW - 1 - NUM_RINGS;

  dec_t dec;
  dma_csr_decode u_dec (.widx(csr_addr), .dec(dec));

  logic                 wr_store, wr_event, wr_txstat, wr_rxstat;
  logic [DW-1:0]        event_q, mask_q, ctrl_q, cmd_q;
  logic [NUM_RINGS-1:0] txh_q, rxh_q, tx_clr, rx_clr;
  logic [DW-1:0]        tx_view, rx_view;

  assign wr_store  = csr_wr && (dec.acc == ACC_RW || dec.acc == ACC_WO);
  assign wr_event  = csr_wr && dec.kind == K_EVENT;
  assign wr_txstat = csr_wr && dec.kind == K_TXSTAT;
  assign wr_rxstat = csr_wr && dec.kind == K_RXSTAT;

  // halt flag bit placement: ring i sits at TX_TOP-i and RX_TOP-i
  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_map
    assign tx_clr[i]          = wr_txstat & csr_wdata[TX_TOP-i];
    assign rx_clr[i]          = wr_rxstat & csr_wdata[RX_TOP-i];
    assign tx_view[TX_TOP-i]  = txh_q[i];
    assign rx_view[RX_TOP-i]  = rxh_q[i];
  end
  assign tx_view[TX_TOP-NUM_RINGS:0] = '0;
  assign rx_view[DW-1:RX_TOP+1]      = '0;
  assign rx_view[RX_TOP-NUM_RINGS:0] = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      event_q <= '0;
      mask_q  <= '0;
      ctrl_q  <= '0;
      cmd_q   <= '0;
      txh_q   <= '0;
      rxh_q   <= '0;
      tx_kick <= '0;
      rx_kick <= '0;
    end else begin
      event_q <= (event_q & ~(wr_event ? csr_wdata : '0)) | evt_set;
      if (wr_store && dec.kind == K_MASK) mask_q <= csr_wdata;
      if (wr_store && dec.kind == K_CTRL) ctrl_q <= csr_wdata;
      if (wr_store && dec.kind == K_CMD)  cmd_q  <= csr_wdata;
      txh_q   <= (txh_q & ~tx_clr) | tx_halt_set;
      rxh_q   <= (rxh_q & ~rx_clr) | rx_halt_set;
      tx_kick <= tx_clr;
      rx_kick <= rx_clr & ~rxh_q;
    end
  end

  logic [NUM_RINGS-1:0][DW-1:0] tx_base, tx_ptr, rx_base, rx_ptr;

  dma_csr_rings #(.N(NUM_RINGS), .W(DW), .ALIGN(3)) u_tx_rings (
    .clk(clk), .rst_n(rst_n),
    .base_we(csr_wr && dec.kind == K_TXBASE),
    .ptr_we(csr_wr && dec.kind == K_TXPTR),
    .sel(dec.ring), .wdata(csr_wdata),
    .base_q(tx_base), .ptr_q(tx_ptr));

  dma_csr_rings #(.N(NUM_RINGS), .W(DW), .ALIGN(3)) u_rx_rings (
    .clk(clk), .rst_n(rst_n),
    .base_we(csr_wr && dec.kind == K_RXBASE),
    .ptr_we(csr_wr && dec.kind == K_RXPTR),
    .sel(dec.ring), .wdata(csr_wdata),
    .base_q(rx_base), .ptr_q(rx_ptr));

  dma_csr_irq #(.W(DW), .TX_GRP(TX_GRP), .RX_GRP(RX_GRP), .ERR_GRP(ERR_GRP)) u_irq (
    .clk(clk), .rst_n(rst_n), .event_q(event_q), .mask_q(mask_q),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err));

  always_comb begin
    case (dec.kind)
      K_EVENT:  csr_rdata = event_q;
      K_MASK:   csr_rdata = mask_q;
      K_CTRL:   csr_rdata = ctrl_q;
      K_ID:     csr_rdata = ID_VALUE;
      K_TXSTAT: csr_rdata = tx_view;
      K_RXSTAT: csr_rdata = rx_view;
      K_TXBASE: csr_rdata = tx_base[dec.ring];
      K_TXPTR:  csr_rdata = tx_ptr[dec.ring];
      K_RXBASE: csr_rdata = rx_base[dec.ring];
      K_RXPTR:  csr_rdata = rx_ptr[dec.ring];
      default:  csr_rdata = '0;
    endcase
    if (dec.acc == ACC_WO) csr_rdata = '0;
  end

  assign cmd_word  = cmd_q;
  assign ctrl_word = ctrl_q;

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_set) != '0 |-> (event_q & $past(evt_set)) == $past(evt_set));
  assert_tx_kick_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_kick != '0 |-> $past(csr_wr && dec.kind == K_TXSTAT));
  assert_tx_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_halt_set) != '0 |-> (txh_q & $past(tx_halt_set)) == $past(tx_halt_set));
  assert_rx_kick_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_kick & $past(rxh_q)) == '0);
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx || irq_rx || irq_err) |-> $past((event_q & mask_q) != '0));
endmodule

// File: tb/dma_csr_bank_tb.sv
module dma_csr_bank_tb_top;
  localparam logic [31:0] IDV = 32'h0DA0_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [11:0] baddr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic [31:0] evt_set = '0;
  logic [7:0]  tx_halt_set = '0, rx_halt_set = '0;
  logic        irq_tx, irq_rx, irq_err;
  logic [7:0]  tx_kick, rx_kick;
  logic [31:0] cmd_word, ctrl_word;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_csr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(baddr[11:2]),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .evt_set(evt_set),
    .tx_halt_set(tx_halt_set), .rx_halt_set(rx_halt_set),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
    .tx_kick(tx_kick), .rx_kick(rx_kick),
    .cmd_word(cmd_word), .ctrl_word(ctrl_word));

  typedef struct packed {
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{12'h004, 32'h1234_5678, 32'h1234_5678, 4'd2},  // R2 mask
    '{12'h008, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 4'd2},  // R2 control
    '{12'h00C, 32'hDEAD_BEEF, 32'h0000_0000, 4'd3},  // R3 write-only
    '{12'h010, 32'hFFFF_FFFF, IDV,           4'd3},  // R3 read-only
    '{12'h10C, 32'h1000_0ABF, 32'h1000_0AB8, 4'd6},  // R6 tx base 3
    '{12'h154, 32'h2000_0007, 32'h2000_0000, 4'd6},  // R6 rx base 5
    '{12'h124, 32'h0000_0013, 32'h0000_0013, 4'd6},  // R6 tx ptr 1
    '{12'h3F0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd1},  // R1 unknown
    '{12'h018, 32'hFFFF_FFFF, 32'h0000_0000, 4'd1}   // R1 gap
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    baddr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [31:0] es, input logic [7:0] ts, input logic [7:0] rs);
    @(negedge clk);
    baddr = a; csr_wdata = d; csr_wr = 1'b1;
    evt_set = es; tx_halt_set = ts; rx_halt_set = rs;
    @(negedge clk);
    csr_wr = 1'b0; evt_set = '0; tx_halt_set = '0; rx_halt_set = '0;
  endtask

  task automatic pulse(input logic [31:0] es, input logic [7:0] ts, input logic [7:0] rs);
    @(negedge clk);
    evt_set = es; tx_halt_set = ts; rx_halt_set = rs;
    @(negedge clk);
    evt_set = '0; tx_halt_set = '0; rx_halt_set = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(12'h000, d); chk("R9 event", d, 0);
    rd(12'h004, d); chk("R9 mask", d, 0);
    rd(12'h010, d); chk("R9 id", d, IDV);
    rd(12'h020, d); chk("R9 txstat", d, 0);
    rd(12'h10C, d); chk("R9 txbase", d, 0);
    chk("R9 outputs", {irq_tx, irq_rx, irq_err, tx_kick, rx_kick}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].addr, VEC[i].wdata, 0, 0, 0);
      rd(VEC[i].addr, d);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].exp);
    end

    chk("R3 cmd_word", cmd_word, 32'hDEAD_BEEF);
    chk("R2 ctrl_word", ctrl_word, 32'hA5A5_0F0F);
    rd(12'h12C, d); chk("R6 tx ptr mirror", d, 32'h1000_0AB8);
    rd(12'h174, d); chk("R6 rx ptr mirror", d, 32'h2000_0000);
    rd(12'h000, d); chk("R1 gap left event", d, 0);

    // R4 / R5 events and interrupts
    wr(12'h004, 32'h0, 0, 0, 0);
    pulse(32'h0001_0101, 0, 0);
    rd(12'h000, d); chk("R4 event set", d, 32'h0001_0101);
    @(negedge clk);
    chk("R5 masked off", {irq_tx, irq_rx, irq_err}, 0);
    wr(12'h004, 32'h0000_0001, 0, 0, 0);
    chk("R5 irq lag", {irq_tx, irq_rx, irq_err}, 3'b000);
    @(negedge clk);
    chk("R5 tx only", {irq_tx, irq_rx, irq_err}, 3'b100);
    wr(12'h004, 32'hFFFF_FFFF, 0, 0, 0);
    @(negedge clk);
    chk("R5 all groups", {irq_tx, irq_rx, irq_err}, 3'b111);
    wr(12'h000, 32'h0000_0100, 0, 0, 0);
    rd(12'h000, d); chk("R4 w1c", d, 32'h0001_0001);
    @(negedge clk);
    chk("R5 rx dropped", {irq_tx, irq_rx, irq_err}, 3'b101);
    wr(12'h000, 32'h0001_0001, 32'h0000_0001, 0, 0);
    rd(12'h000, d); chk("R4 set beats clear", d, 32'h0000_0001);
    @(negedge clk);
    chk("R5 err dropped", {irq_tx, irq_rx, irq_err}, 3'b100);

    // R7 transmit halt
    pulse(0, 8'h05, 0);
    rd(12'h020, d); chk("R7 flags", d, 32'hA000_0000);
    wr(12'h020, 32'h8100_0000, 0, 0, 0);
    chk("R7 kick", {24'h0, tx_kick}, 32'h81);
    rd(12'h020, d); chk("R7 cleared", d, 32'h2000_0000);
    @(negedge clk);
    chk("R7 kick one cycle", {24'h0, tx_kick}, 0);
    wr(12'h020, 32'h1000_0000, 0, 8'h08, 0);
    rd(12'h020, d); chk("R7 set beats clear", d, 32'h3000_0000);
    chk("R7 kick ring3", {24'h0, tx_kick}, 32'h08);

    // R8 receive halt
    pulse(0, 0, 8'h02);
    rd(12'h024, d); chk("R8 flag", d, 32'h0040_0000);
    wr(12'h024, 32'h0060_0000, 0, 0, 0);
    chk("R8 kick only clear ring", {24'h0, rx_kick}, 32'h04);
    rd(12'h024, d); chk("R8 cleared", d, 0);
    @(negedge clk);
    chk("R8 kick one cycle", {24'h0, rx_kick}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule